// File: doc/BRIEF.md
# Host Command Mailbox with Doorbells

This block is the device side of a byte-wide command mailbox between a host and an embedded management controller. The host sees an 8-byte register window and uses three of its offsets. Offset 4 is a transfer-control register. Offset 5 is a data port into a shared byte buffer. Offset 6 is an interrupt-mask register. The host clears its write pointer and loads a command into the buffer byte by byte. It then rings a doorbell toward the controller and waits for the doorbell coming back. After that it takes the host-busy semaphore, acknowledges the return doorbell, rewinds its read pointer, reads the reply and releases the semaphore.

The controller side is a simple local port. It reads and writes any buffer byte by address, and it has strobes that accept a pending command and post a reply. Two further strobes raise the event and heartbeat doorbells, and a level input drives the controller-busy flag. A four-state handshake machine owns both directional doorbells:

- BELL_IDLE goes to BELL_POSTED when the host rings (ring).
- BELL_POSTED goes to BELL_SERVICE when the controller accepts (accept).
- BELL_POSTED or BELL_SERVICE goes to BELL_REPLY when the controller posts a reply (reply). A reply takes priority over an accept in the same cycle.
- BELL_REPLY goes back to BELL_IDLE when the host acknowledges (ack).

The host may start a new command only when the host doorbell, the return doorbell and the controller-busy bit all read zero.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the control register (offset 4) and the mask register (offset 6) read 0x00, both buffer pointers are zero, and every buffer byte reads 0x00.
- R2: Writing 1 to control bit 0 resets the host write pointer. Writing 1 to control bit 1 resets the host read pointer. Both bits always read back as 0.
- R3: A host write to offset 5 stores the byte at the write pointer and advances it. Reading offset 5 returns the byte at the read pointer, and a read strobe advances that pointer. The two pointers move independently, and the read pointer wraps to 0 after the last buffer entry.
- R4: Once 32 bytes have been written since the last write-pointer reset, further data writes are dropped and leave the buffer unchanged.
- R5: Control bit 2 (host doorbell) reads 1 only in BELL_POSTED, and control bit 3 (return doorbell) reads 1 only in BELL_REPLY. Writing 1 to bit 2 rings only from BELL_IDLE. An accept clears bit 2. A reply sets bit 3. Writing 1 to bit 3 acknowledges the reply and returns the machine to idle.
- R6: Control bit 7 shows the controller-busy input delayed by one clock.
- R7: Each host write with control bit 6 set toggles the host-busy semaphore, which reads back on bit 6.
- R8: While host busy is set, controller-side buffer writes are ignored.
- R9: Controller strobes set control bit 4 (event doorbell) and bit 5 (heartbeat doorbell). Writing 1 to either bit clears it, and writing 0 leaves it unchanged.
- R10: In the mask register, bits 2, 3 and 4 are plain read/write enables. Bit 1 (reply pending) is set when the return doorbell is raised and cleared by writing 1. Bits 0, 5, 6 and 7 read 0.
- R11: Host writes to offsets other than 4, 5 and 6 change nothing, and reads from those offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Host register offset within the window |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; advances the read pointer at offset 5 |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the current host offset |
| ec_addr | input | 5 | Controller buffer address |
| ec_we | input | 1 | Controller buffer write strobe |
| ec_wdata | input | 8 | Controller buffer write data |
| ec_rdata | output | 8 | Buffer byte at ec_addr |
| ec_accept | input | 1 | Controller takes the posted command |
| ec_reply | input | 1 | Controller raises the return doorbell |
| ec_event | input | 1 | Sets the event doorbell |
| ec_heartbeat | input | 1 | Sets the heartbeat doorbell |
| ec_busy | input | 1 | Controller-busy level |
| ec_cmd_pending | output | 1 | Host doorbell is ringing |
| ec_host_busy | output | 1 | Host-busy semaphore is held |

## Verification
On every cycle the assertions check the one-cycle relations: pointer resets, write-pointer saturation, the clearing of each doorbell by its owner, the semaphore toggle and the controller-busy delay. Only the bench scenarios can show the complete command round trip through the buffer. The same holds for several ignored-input cases: a ring while a command is already pending, controller writes blocked by the semaphore, and dead offsets in the window. The read-pointer wrap and the no-overwrite behaviour after a 33-byte burst are also visible only in the scenarios.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned BYTE_W = 8;

    // register offsets inside the 8-byte host window
    localparam logic [2:0] OFS_CTRL = 3'd4;
    localparam logic [2:0] OFS_DATA = 3'd5;
    localparam logic [2:0] OFS_MASK = 3'd6;

    // control register bit positions
    localparam int unsigned CB_CLR_WP = 0;
    localparam int unsigned CB_CLR_RP = 1;
    localparam int unsigned CB_H2C    = 2;
    localparam int unsigned CB_C2H    = 3;
    localparam int unsigned CB_EVENT  = 4;
    localparam int unsigned CB_BEAT   = 5;
    localparam int unsigned CB_HBUSY  = 6;
    localparam int unsigned CB_CBUSY  = 7;

    typedef enum logic [1:0] {
        BELL_IDLE    = 2'd0,
        BELL_POSTED  = 2'd1,
        BELL_SERVICE = 2'd2,
        BELL_REPLY   = 2'd3
    } bell_state_e;

endpackage

// File: rtl/mbx_store.sv
module mbx_store
    import mbx_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned PW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_wptr,
    input  logic              clr_rptr,
    input  logic              h_push,
    input  logic [BYTE_W-1:0] h_wdata,
    input  logic              h_pop,
    output logic [BYTE_W-1:0] h_rdata,
    input  logic [PW-1:0]     ec_addr,
    input  logic              ec_we,
    input  logic [BYTE_W-1:0] ec_wdata,
    output logic [BYTE_W-1:0] ec_rdata,
    output logic [PW:0]       wptr
);

    localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

    logic [PW-1:0]     rptr;
    logic              push_ok;
    logic [BYTE_W-1:0] cells [DEPTH];

    assign push_ok = h_push && (wptr != FULL_CNT);

    // write pointer saturates at DEPTH; pushes beyond that are dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
        end else if (clr_wptr) begin
            wptr <= '0;
        end else if (push_ok) begin
            wptr <= wptr + 1'b1;
        end
    end

    // read pointer wraps modulo DEPTH (DEPTH is a power of two)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr <= '0;
        end else if (clr_rptr) begin
            rptr <= '0;
        end else if (h_pop) begin
            rptr <= rptr + 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic              host_hit;
        logic              ec_hit;
        logic [BYTE_W-1:0] cell_q;

        assign host_hit = push_ok && (wptr[PW-1:0] == PW'(g));
        assign ec_hit   = ec_we && (ec_addr == PW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else if (host_hit) begin
                cell_q <= h_wdata;
            end else if (ec_hit) begin
                cell_q <= ec_wdata;
            end
        end

        assign cells[g] = cell_q;
    end

    assign h_rdata  = cells[rptr];
    assign ec_rdata = cells[ec_addr];

endmodule

// File: rtl/mbx_bell_fsm.sv
module mbx_bell_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_ring,
    input  logic host_ack,
    input  logic ec_accept,
    input  logic ec_reply,
    output logic h2c_bell,
    output logic c2h_bell,
    output logic reply_enter
);

    bell_state_e state_q;
    bell_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BELL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BELL_IDLE: begin
                if (host_ring) state_d = BELL_POSTED;
            end
            BELL_POSTED: begin
                if (ec_reply)       state_d = BELL_REPLY;
                else if (ec_accept) state_d = BELL_SERVICE;
            end
            BELL_SERVICE: begin
                if (ec_reply) state_d = BELL_REPLY;
            end
            BELL_REPLY: begin
                if (host_ack) state_d = BELL_IDLE;
            end
            default: state_d = BELL_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        h2c_bell    = 1'b0;
        c2h_bell    = 1'b0;
        reply_enter = 1'b0;
        unique case (state_q)
            BELL_IDLE:    ;
            BELL_POSTED: begin
                h2c_bell    = 1'b1;
                reply_enter = ec_reply;
            end
            BELL_SERVICE: reply_enter = ec_reply;
            BELL_REPLY:   c2h_bell = 1'b1;
            default:      ;
        endcase
    end

endmodule

// File: rtl/mbx_status_regs.sv
module mbx_status_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [6:4] ctrl_bits,
    input  logic       mask_wr,
    input  logic [4:1] mask_bits,
    input  logic       ev_set,
    input  logic       beat_set,
    input  logic       busy_in,
    input  logic       reply_enter,
    output logic       ev_q,
    output logic       beat_q,
    output logic       hbusy_q,
    output logic       cbusy_q,
    output logic [7:0] mask_view
);

    logic [2:0] irq_en_q;
    logic       pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q     <= 1'b0;
            beat_q   <= 1'b0;
            hbusy_q  <= 1'b0;
            cbusy_q  <= 1'b0;
            irq_en_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            cbusy_q <= busy_in;

            // controller set wins over a host clear in the same cycle
            if (ev_set)                       ev_q <= 1'b1;
            else if (ctrl_wr && ctrl_bits[4]) ev_q <= 1'b0;

            if (beat_set)                     beat_q <= 1'b1;
            else if (ctrl_wr && ctrl_bits[5]) beat_q <= 1'b0;

            if (ctrl_wr && ctrl_bits[6]) hbusy_q <= ~hbusy_q;

            if (mask_wr) irq_en_q <= mask_bits[4:2];

            if (reply_enter)                  pend_q <= 1'b1;
            else if (mask_wr && mask_bits[1]) pend_q <= 1'b0;
        end
    end

    assign mask_view = {3'b000, irq_en_q, pend_q, 1'b0};

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned PW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic [PW-1:0]     ec_addr,
    input  logic              ec_we,
    input  logic [BYTE_W-1:0] ec_wdata,
    output logic [BYTE_W-1:0] ec_rdata,
    input  logic              ec_accept,
    input  logic              ec_reply,
    input  logic              ec_event,
    input  logic              ec_heartbeat,
    input  logic              ec_busy,
    output logic              ec_cmd_pending,
    output logic              ec_host_busy
);

    logic              ctrl_wr;
    logic              data_wr;
    logic              mask_wr;
    logic              data_rd;
    logic              host_ring;
    logic              host_ack;
    logic              bell_h2c;
    logic              bell_c2h;
    logic              reply_enter;
    logic              ev_q;
    logic              beat_q;
    logic              host_busy_q;
    logic              busy_q;
    logic [7:0]        mask_view;
    logic [BYTE_W-1:0] buf_rdata;
    logic [BYTE_W-1:0] ctrl_view;
    logic [PW:0]       wr_ptr;
    logic              ec_we_ok;

    assign ctrl_wr   = host_wr && (host_addr == OFS_CTRL);
    assign data_wr   = host_wr && (host_addr == OFS_DATA);
    assign mask_wr   = host_wr && (host_addr == OFS_MASK);
    assign data_rd   = host_rd && (host_addr == OFS_DATA);
    assign host_ring = ctrl_wr && host_wdata[CB_H2C];
    assign host_ack  = ctrl_wr && host_wdata[CB_C2H];
    assign ec_we_ok  = ec_we && !host_busy_q;

    mbx_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_wptr (ctrl_wr && host_wdata[CB_CLR_WP]),
        .clr_rptr (ctrl_wr && host_wdata[CB_CLR_RP]),
        .h_push   (data_wr),
        .h_wdata  (host_wdata),
        .h_pop    (data_rd),
        .h_rdata  (buf_rdata),
        .ec_addr  (ec_addr),
        .ec_we    (ec_we_ok),
        .ec_wdata (ec_wdata),
        .ec_rdata (ec_rdata),
        .wptr     (wr_ptr)
    );

    mbx_bell_fsm u_bell (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_ring   (host_ring),
        .host_ack    (host_ack),
        .ec_accept   (ec_accept),
        .ec_reply    (ec_reply),
        .h2c_bell    (bell_h2c),
        .c2h_bell    (bell_c2h),
        .reply_enter (reply_enter)
    );

    mbx_status_regs u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (ctrl_wr),
        .ctrl_bits   (host_wdata[6:4]),
        .mask_wr     (mask_wr),
        .mask_bits   (host_wdata[4:1]),
        .ev_set      (ec_event),
        .beat_set    (ec_heartbeat),
        .busy_in     (ec_busy),
        .reply_enter (reply_enter),
        .ev_q        (ev_q),
        .beat_q      (beat_q),
        .hbusy_q     (host_busy_q),
        .cbusy_q     (busy_q),
        .mask_view   (mask_view)
    );

    // pointer-reset strobes always read as zero
    assign ctrl_view = {busy_q, host_busy_q, beat_q, ev_q, bell_c2h, bell_h2c, 2'b00};

    always_comb begin
        unique case (host_addr)
            OFS_CTRL: host_rdata = ctrl_view;
            OFS_DATA: host_rdata = buf_rdata;
            OFS_MASK: host_rdata = mask_view;
            default:  host_rdata = '0;
        endcase
    end

    assign ec_cmd_pending = bell_h2c;
    assign ec_host_busy   = host_busy_q;

endmodule

// File: rtl/cmd_mailbox_chk.sv
module cmd_mailbox_chk #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned PW   = $clog2(DEPTH)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ctrl_wr,
    input logic        data_wr,
    input logic [7:0]  host_wdata,
    input logic        ec_accept,
    input logic        ec_reply,
    input logic        ec_busy,
    input logic        bell_h2c,
    input logic        bell_c2h,
    input logic [PW:0] wr_ptr,
    input logic        host_busy_q,
    input logic        busy_q
);

    localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

    // R2
    wp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && host_wdata[0]) |=> (wr_ptr == '0));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr == FULL_CNT && data_wr) |=> (wr_ptr == FULL_CNT));

    // R5
    accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bell_h2c && ec_accept && !ec_reply) |=> (!bell_h2c && !bell_c2h));

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bell_c2h && ctrl_wr && host_wdata[3]) |=> !bell_c2h);

    // R5
    reply_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bell_h2c || (!bell_c2h && !bell_h2c && !(ctrl_wr && host_wdata[2]))) && ec_reply && bell_h2c)
        |=> bell_c2h);

    // R6
    busy_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ec_busy |=> busy_q);

    // R6
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ec_busy |=> !busy_q);

    // R7
    sem_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && host_wdata[6]) |=> (host_busy_q != $past(host_busy_q)));

endmodule

bind cmd_mailbox cmd_mailbox_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_wr     (ctrl_wr),
    .data_wr     (data_wr),
    .host_wdata  (host_wdata),
    .ec_accept   (ec_accept),
    .ec_reply    (ec_reply),
    .ec_busy     (ec_busy),
    .bell_h2c    (bell_h2c),
    .bell_c2h    (bell_c2h),
    .wr_ptr      (wr_ptr),
    .host_busy_q (host_busy_q),
    .busy_q      (busy_q)
);

// File: tb/cmd_mailbox_test.sv
module cmd_mailbox_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [4:0] ec_addr = 5'd0;
    logic       ec_we = 1'b0;
    logic [7:0] ec_wdata = 8'h00;
    logic [7:0] ec_rdata;
    logic       ec_accept = 1'b0;
    logic       ec_reply = 1'b0;
    logic       ec_event = 1'b0;
    logic       ec_heartbeat = 1'b0;
    logic       ec_busy = 1'b0;
    logic       ec_cmd_pending;
    logic       ec_host_busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_mailbox #(.DEPTH(DEPTH)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_addr      (host_addr),
        .host_wr        (host_wr),
        .host_rd        (host_rd),
        .host_wdata     (host_wdata),
        .host_rdata     (host_rdata),
        .ec_addr        (ec_addr),
        .ec_we          (ec_we),
        .ec_wdata       (ec_wdata),
        .ec_rdata       (ec_rdata),
        .ec_accept      (ec_accept),
        .ec_reply       (ec_reply),
        .ec_event       (ec_event),
        .ec_heartbeat   (ec_heartbeat),
        .ec_busy        (ec_busy),
        .ec_cmd_pending (ec_cmd_pending),
        .ec_host_busy   (ec_host_busy)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_peek(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b0;
        #1 d = host_rdata;
    endtask

    task automatic host_pop(output logic [7:0] d);
        @(negedge clk);
        host_addr = 3'd5; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic ec_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        ec_addr = a; ec_wdata = d; ec_we = 1'b1;
        @(negedge clk);
        ec_we = 1'b0;
    endtask

    task automatic ec_peek(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        ec_addr = a;
        #1 d = ec_rdata;
    endtask

    // 0 accept, 1 reply, 2 event, 3 heartbeat
    task automatic ec_strobe(input int which);
        @(negedge clk);
        case (which)
            0: ec_accept = 1'b1;
            1: ec_reply = 1'b1;
            2: ec_event = 1'b1;
            default: ec_heartbeat = 1'b1;
        endcase
        @(negedge clk);
        ec_accept = 1'b0; ec_reply = 1'b0; ec_event = 1'b0; ec_heartbeat = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        host_peek(3'd4, v); check("R1 ctrl", v, 8'h00);
        host_peek(3'd6, v); check("R1 mask", v, 8'h00);
        host_peek(3'd5, v); check("R1 data", v, 8'h00);
    endtask

    task automatic t_fill_drain();
        logic [7:0] v;
        host_write(3'd4, 8'h01);
        host_peek(3'd4, v); check("R2 strobe readback", v, 8'h00);
        for (int i = 0; i < 5; i++) host_write(3'd5, 8'hA0 + 8'(i));
        host_write(3'd4, 8'h02);
        for (int i = 0; i < 5; i++) begin
            host_pop(v); check("R3 drain", v, 8'hA0 + 8'(i));
        end
        // pointers independent: write side continues from 5, read side from 5
        host_write(3'd5, 8'hA5);
        host_pop(v); check("R3 independent", v, 8'hA5);
        host_write(3'd4, 8'h03);
        host_peek(3'd4, v); check("R2 both strobes", v, 8'h00);
        host_pop(v); check("R2 rptr reset", v, 8'hA0);
    endtask

    task automatic t_overflow();
        logic [7:0] v;
        host_write(3'd4, 8'h01);
        for (int i = 0; i < DEPTH; i++) host_write(3'd5, 8'h40 + 8'(i));
        host_write(3'd5, 8'hEE);
        host_write(3'd4, 8'h02);
        for (int i = 0; i < DEPTH; i++) begin
            host_pop(v); check("R4 contents", v, 8'h40 + 8'(i));
        end
        host_pop(v); check("R3 wrap and R4 drop", v, 8'h40);
    endtask

    task automatic t_handshake();
        logic [7:0] v;
        host_write(3'd4, 8'h01);
        host_write(3'd5, 8'h5A);
        host_write(3'd5, 8'h3C);
        host_write(3'd4, 8'h04);
        host_peek(3'd4, v); check("R5 ring", v, 8'h04);
        check("R5 pending out", {7'd0, ec_cmd_pending}, 8'h01);
        host_write(3'd4, 8'h04);
        host_peek(3'd4, v); check("R5 re-ring", v, 8'h04);
        ec_strobe(0);
        host_peek(3'd4, v); check("R5 accept", v, 8'h00);
        ec_peek(5'd0, v); check("R5 ec sees cmd", v, 8'h5A);
        ec_write(5'd0, 8'hC1);
        ec_write(5'd1, 8'hC2);
        ec_strobe(1);
        host_peek(3'd4, v); check("R5 reply", v, 8'h08);
        host_peek(3'd6, v); check("R10 pending", v, 8'h02);
        host_write(3'd4, 8'h04);
        host_peek(3'd4, v); check("R5 ring in reply ignored", v, 8'h08);
        host_write(3'd4, 8'h40);
        host_peek(3'd4, v); check("R7 take sem", v, 8'h48);
        host_write(3'd4, 8'h08);
        host_peek(3'd4, v); check("R5 ack", v, 8'h40);
        host_write(3'd4, 8'h02);
        host_pop(v); check("R3 reply byte0", v, 8'hC1);
        host_pop(v); check("R3 reply byte1", v, 8'hC2);
        host_write(3'd4, 8'h40);
        host_peek(3'd4, v); check("R7 release sem", v, 8'h00);
        host_write(3'd6, 8'h02);
        host_peek(3'd6, v); check("R10 pending clear", v, 8'h00);
    endtask

    task automatic t_semaphore();
        logic [7:0] v;
        ec_write(5'd3, 8'h11);
        host_write(3'd4, 8'h40);
        check("R7 sem out", {7'd0, ec_host_busy}, 8'h01);
        ec_write(5'd3, 8'h99);
        ec_peek(5'd3, v); check("R8 blocked", v, 8'h11);
        host_write(3'd4, 8'h40);
        host_peek(3'd4, v); check("R7 toggle off", v, 8'h00);
        ec_write(5'd3, 8'h99);
        ec_peek(5'd3, v); check("R8 unblocked", v, 8'h99);
    endtask

    task automatic t_busy();
        logic [7:0] v;
        @(negedge clk);
        ec_busy = 1'b1;
        #1 check("R6 delay", host_rdata, 8'h00);
        @(negedge clk);
        #1 check("R6 set", host_rdata, 8'h80);
        ec_busy = 1'b0;
        host_peek(3'd4, v); check("R6 clear", v, 8'h00);
    endtask

    task automatic t_events();
        logic [7:0] v;
        ec_strobe(2);
        host_peek(3'd4, v); check("R9 event", v, 8'h10);
        ec_strobe(3);
        host_peek(3'd4, v); check("R9 heartbeat", v, 8'h30);
        host_write(3'd4, 8'h00);
        host_peek(3'd4, v); check("R9 write zero", v, 8'h30);
        host_write(3'd4, 8'h10);
        host_peek(3'd4, v); check("R9 clear event", v, 8'h20);
        host_write(3'd4, 8'h20);
        host_peek(3'd4, v); check("R9 clear heartbeat", v, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        host_write(3'd6, 8'hFF);
        host_peek(3'd6, v); check("R10 enables", v, 8'h1C);
        host_write(3'd6, 8'h00);
        host_peek(3'd6, v); check("R10 disable", v, 8'h00);
    endtask

    task automatic t_dead_offsets();
        logic [7:0] v;
        host_write(3'd6, 8'h04);
        for (int a = 0; a < 8; a++) begin
            if (a < 4 || a == 7) host_write(3'(a), 8'hFF);
        end
        for (int a = 0; a < 8; a++) begin
            if (a < 4 || a == 7) begin
                host_peek(3'(a), v); check("R11 dead read", v, 8'h00);
            end
        end
        host_peek(3'd4, v); check("R11 ctrl untouched", v, 8'h00);
        host_peek(3'd6, v); check("R11 mask untouched", v, 8'h04);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_drain();
        t_overflow();
        t_handshake();
        t_semaphore();
        t_busy();
        t_events();
        t_mask();
        t_dead_offsets();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule